// File: doc/BRIEF.md
# Keyboard Controller Host Register Block

This block is the host side of a PC-style keyboard and auxiliary-device controller. The host writes single-byte controller commands on one write port and data bytes on a second write port, and reads an 8-bit status byte. The block holds an 8-bit mode register, an 8-bit status register and an 8-bit output port. It decodes each command, and it produces reply bytes on a one-cycle valid/data channel tagged with their source (keyboard or auxiliary). It also drives the address-gate (A20) line and a one-cycle system-reset request.

Several commands take an argument. These two-phase commands latch a pending target, and the next data write is steered to it: the mode register, the output port, a keyboard-sourced reply, an auxiliary-sourced reply, or a byte forwarded to the auxiliary device. A data write with nothing pending is forwarded to the keyboard device. The pending target lives in a small state machine with states ST_IDLE, ST_ARG_MODE, ST_ARG_OUTP, ST_ARG_KREPLY, ST_ARG_AREPLY and ST_ARG_AUXFWD. It has three transitions:
- Latch: a two-phase command moves the machine from any state to its target state.
- Hold: a single-phase command, or no write at all, keeps the state.
- Consume: a data write with no command in the same cycle returns the machine to ST_IDLE.

All outputs are registered. A command or data byte sampled on a rising edge shows its effect right after that edge.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset the mode register is 0x03, status_o is 0x18, the output port is 0xCF, a20_o is 1, and sys_rst_req_o, xlate_en_o, err_o and all valid outputs are 0.
- R2: Command 0x20 replies with the mode register, 0xD0 replies with the output port, and 0xC0 replies with 0x80. Each reply appears with rsp_valid_o high and rsp_aux_o low for exactly the cycle after the command.
- R3: Commands 0x60, 0xD1, 0xD2, 0xD3 and 0xD4 produce nothing by themselves. The next data byte then becomes, in that order: the new mode, the new output port, a reply with rsp_aux_o=0, a reply with rsp_aux_o=1, or a byte on the auxiliary forward channel.
- R4: Any data write clears the pending target. A data write with nothing pending appears on the keyboard forward channel the cycle after the write.
- R5: Command 0xAA sets status bit 2, which stays set until reset, and replies 0x55. Commands 0xAB and 0xA9 each reply 0x00.
- R6: Commands 0xA7 and 0xA8 set and clear mode bit 5. Commands 0xAD and 0xAE set and clear mode bit 4.
- R7: Any command whose upper nibble is 0xF is a pulse command. With bit 0 equal to 0 it raises sys_rst_req_o for one cycle. With bit 0 equal to 1 it does nothing.
- R8: Command 0xDF sets output-port bit 1 and drives a20_o high. Command 0xDD clears that bit and drives a20_o low.
- R9: A write to the output port drives a20_o from data bit 1. A 0 in data bit 0 raises sys_rst_req_o for one cycle.
- R10: A command outside the set listed in R2 to R8 changes no register and produces no output, and it sets err_o, which stays set until reset.
- R11: A data write that loads the mode register sets xlate_en_o to data bit 6. Other writes leave xlate_en_o unchanged.
- R12: A single-phase command issued while an argument is pending leaves the pending target in place. A new two-phase command replaces it.
- R13: When cmd_we and dat_we are high in the same cycle, the command is executed, the data byte is dropped, and the pending target is unchanged by the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Controller command |
| dat_we | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data / argument byte |
| status_o | output | 8 | Status register |
| rsp_valid_o | output | 1 | Reply byte valid (one cycle) |
| rsp_data_o | output | 8 | Reply byte |
| rsp_aux_o | output | 1 | Reply is auxiliary-sourced |
| kbd_fwd_valid_o | output | 1 | Byte forwarded to keyboard device valid |
| kbd_fwd_data_o | output | 8 | Byte forwarded to keyboard device |
| aux_fwd_valid_o | output | 1 | Byte forwarded to auxiliary device valid |
| aux_fwd_data_o | output | 8 | Byte forwarded to auxiliary device |
| a20_o | output | 1 | Address gate line (output-port bit 1) |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| xlate_en_o | output | 1 | Translation enable level (mode bit 6) |
| err_o | output | 1 | Sticky unknown-command flag |

## Verification
The bench targets the pulse-command decode at 0xF0, 0xF1, 0xFE and 0xFF. A decoder that matches only 0xFE would miss the reset at 0xF0, and one that ignores bit 0 would reset on 0xF1 or 0xFF. It also issues a single-phase command in the middle of a two-phase exchange, and a command and a data byte in the same cycle. A design that cleared the latch on any command would send the later argument to the keyboard instead of the reply channel, and one that let the data byte through would produce a stray forward or consume the latch. Output-port writes are checked with bit 0 both set and clear and bit 1 both ways, which catches a reset pulse with the wrong polarity and an address-gate line taken from the wrong bit. An unknown command is shown to leave the mode untouched while setting the error flag.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    // command codes
    localparam byte_t CMD_RD_MODE   = 8'h20;
    localparam byte_t CMD_WR_MODE   = 8'h60;
    localparam byte_t CMD_AUX_OFF   = 8'hA7;
    localparam byte_t CMD_AUX_ON    = 8'hA8;
    localparam byte_t CMD_AUX_TEST  = 8'hA9;
    localparam byte_t CMD_SELFTEST  = 8'hAA;
    localparam byte_t CMD_KBD_TEST  = 8'hAB;
    localparam byte_t CMD_KBD_OFF   = 8'hAD;
    localparam byte_t CMD_KBD_ON    = 8'hAE;
    localparam byte_t CMD_RD_INP    = 8'hC0;
    localparam byte_t CMD_RD_OUTP   = 8'hD0;
    localparam byte_t CMD_WR_OUTP   = 8'hD1;
    localparam byte_t CMD_WR_KREPLY = 8'hD2;
    localparam byte_t CMD_WR_AREPLY = 8'hD3;
    localparam byte_t CMD_WR_AUX    = 8'hD4;
    localparam byte_t CMD_GATE_OFF  = 8'hDD;
    localparam byte_t CMD_GATE_ON   = 8'hDF;
    localparam logic [3:0] PULSE_NIBBLE = 4'hF;

    // reply constants
    localparam byte_t INPORT_VALUE = 8'h80;
    localparam byte_t SELFTEST_OK  = 8'h55;
    localparam byte_t IFTEST_OK    = 8'h00;

    // bit positions
    localparam int MODE_KBD_OFF_BIT = 4;
    localparam int MODE_AUX_OFF_BIT = 5;
    localparam int MODE_XLATE_BIT   = 6;
    localparam int STAT_TEST_BIT    = 2;
    localparam int OUTP_RUN_BIT     = 0;
    localparam int OUTP_GATE_BIT    = 1;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_RD_MODE,
        OP_RD_OUTP,
        OP_RD_INP,
        OP_ARG,
        OP_SELFTEST,
        OP_IF_TEST,
        OP_AUX_OFF,
        OP_AUX_ON,
        OP_KBD_OFF,
        OP_KBD_ON,
        OP_GATE_ON,
        OP_GATE_OFF,
        OP_CPU_RST,
        OP_BAD
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG_MODE,
        ST_ARG_OUTP,
        ST_ARG_KREPLY,
        ST_ARG_AREPLY,
        ST_ARG_AUXFWD
    } phase_e;

endpackage

// File: rtl/kbc_cmd_classify.sv
module kbc_cmd_classify
    import kbc_pkg::*;
(
    input  logic [BYTE_W-1:0] cmd,
    output op_e               op,
    output phase_e            arg_phase
);

    always_comb begin
        op        = OP_BAD;
        arg_phase = ST_IDLE;
        if (cmd[7:4] == PULSE_NIBBLE) begin
            // pulse command: only bit 0 (reset line) matters
            op = cmd[0] ? OP_NOP : OP_CPU_RST;
        end else begin
            unique case (cmd)
                CMD_RD_MODE:   op = OP_RD_MODE;
                CMD_RD_OUTP:   op = OP_RD_OUTP;
                CMD_RD_INP:    op = OP_RD_INP;
                CMD_SELFTEST:  op = OP_SELFTEST;
                CMD_KBD_TEST:  op = OP_IF_TEST;
                CMD_AUX_TEST:  op = OP_IF_TEST;
                CMD_AUX_OFF:   op = OP_AUX_OFF;
                CMD_AUX_ON:    op = OP_AUX_ON;
                CMD_KBD_OFF:   op = OP_KBD_OFF;
                CMD_KBD_ON:    op = OP_KBD_ON;
                CMD_GATE_ON:   op = OP_GATE_ON;
                CMD_GATE_OFF:  op = OP_GATE_OFF;
                CMD_WR_MODE:   begin op = OP_ARG; arg_phase = ST_ARG_MODE;   end
                CMD_WR_OUTP:   begin op = OP_ARG; arg_phase = ST_ARG_OUTP;   end
                CMD_WR_KREPLY: begin op = OP_ARG; arg_phase = ST_ARG_KREPLY; end
                CMD_WR_AREPLY: begin op = OP_ARG; arg_phase = ST_ARG_AREPLY; end
                CMD_WR_AUX:    begin op = OP_ARG; arg_phase = ST_ARG_AUXFWD; end
                default:       op = OP_BAD;
            endcase
        end
    end

endmodule

// File: rtl/kbc_phase_fsm.sv
module kbc_phase_fsm
    import kbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   cmd_we,
    input  logic   dat_we,
    input  op_e    op,
    input  phase_e arg_phase,
    output phase_e state
);

    phase_e state_q, state_d;

    // next-state: latch / hold / consume
    always_comb begin
        state_d = state_q;
        if (cmd_we) begin
            if (op == OP_ARG) state_d = arg_phase;
        end else if (dat_we) begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;

    AST_DATA_CLEARS_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_we && !cmd_we) |=> (state_q == ST_IDLE)); // R4

    AST_SINGLE_KEEPS_ARG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && op != OP_ARG) |=> $stable(state_q)); // R12

endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
    import kbc_pkg::*;
#(
    parameter logic [7:0] MODE_INIT = 8'h03,
    parameter logic [7:0] STAT_INIT = 8'h18,
    parameter logic [7:0] OUTP_INIT = 8'hCF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic       dat_we,
    input  logic [7:0] dat_byte,
    output logic [7:0] status_o,
    output logic       rsp_valid_o,
    output logic [7:0] rsp_data_o,
    output logic       rsp_aux_o,
    output logic       kbd_fwd_valid_o,
    output logic [7:0] kbd_fwd_data_o,
    output logic       aux_fwd_valid_o,
    output logic [7:0] aux_fwd_data_o,
    output logic       a20_o,
    output logic       sys_rst_req_o,
    output logic       xlate_en_o,
    output logic       err_o
);

    op_e    op;
    phase_e arg_phase;
    phase_e phase;

    kbc_cmd_classify u_classify (
        .cmd       (cmd_byte),
        .op        (op),
        .arg_phase (arg_phase)
    );

    kbc_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (cmd_we),
        .dat_we    (dat_we),
        .op        (op),
        .arg_phase (arg_phase),
        .state     (phase)
    );

    byte_t mode_q, stat_q, outp_q, mode_d, stat_d, outp_d;
    byte_t rsp_q, rsp_d, kf_q, kf_d, af_q, af_d;
    logic  rsp_v_q, rsp_v_d, rsp_aux_q, rsp_aux_d;
    logic  kf_v_q, kf_v_d, af_v_q, af_v_d;
    logic  rst_q, rst_d, xl_q, xl_d, err_q, err_d;

    // action decode: commands take priority over data in the same cycle
    always_comb begin
        mode_d    = mode_q;
        stat_d    = stat_q;
        outp_d    = outp_q;
        rsp_v_d   = 1'b0;
        rsp_d     = '0;
        rsp_aux_d = 1'b0;
        kf_v_d    = 1'b0;
        kf_d      = '0;
        af_v_d    = 1'b0;
        af_d      = '0;
        rst_d     = 1'b0;
        xl_d      = xl_q;
        err_d     = err_q;
        if (cmd_we) begin
            unique case (op)
                OP_RD_MODE:  begin rsp_v_d = 1'b1; rsp_d = mode_q;       end
                OP_RD_OUTP:  begin rsp_v_d = 1'b1; rsp_d = outp_q;       end
                OP_RD_INP:   begin rsp_v_d = 1'b1; rsp_d = INPORT_VALUE; end
                OP_SELFTEST: begin
                    stat_d[STAT_TEST_BIT] = 1'b1;
                    rsp_v_d = 1'b1;
                    rsp_d   = SELFTEST_OK;
                end
                OP_IF_TEST:  begin rsp_v_d = 1'b1; rsp_d = IFTEST_OK;    end
                OP_AUX_OFF:  mode_d[MODE_AUX_OFF_BIT] = 1'b1;
                OP_AUX_ON:   mode_d[MODE_AUX_OFF_BIT] = 1'b0;
                OP_KBD_OFF:  mode_d[MODE_KBD_OFF_BIT] = 1'b1;
                OP_KBD_ON:   mode_d[MODE_KBD_OFF_BIT] = 1'b0;
                OP_GATE_ON:  outp_d[OUTP_GATE_BIT] = 1'b1;
                OP_GATE_OFF: outp_d[OUTP_GATE_BIT] = 1'b0;
                OP_CPU_RST:  rst_d = 1'b1;
                OP_BAD:      err_d = 1'b1;
                default:     ;
            endcase
        end else if (dat_we) begin
            unique case (phase)
                ST_IDLE:       begin kf_v_d = 1'b1; kf_d = dat_byte; end
                ST_ARG_MODE:   begin
                    mode_d = dat_byte;
                    xl_d   = dat_byte[MODE_XLATE_BIT];
                end
                ST_ARG_OUTP:   begin
                    outp_d = dat_byte;
                    rst_d  = ~dat_byte[OUTP_RUN_BIT];
                end
                ST_ARG_KREPLY: begin rsp_v_d = 1'b1; rsp_d = dat_byte; end
                ST_ARG_AREPLY: begin
                    rsp_v_d   = 1'b1;
                    rsp_d     = dat_byte;
                    rsp_aux_d = 1'b1;
                end
                ST_ARG_AUXFWD: begin af_v_d = 1'b1; af_d = dat_byte; end
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_INIT;
            stat_q    <= STAT_INIT;
            outp_q    <= OUTP_INIT;
            rsp_v_q   <= 1'b0;
            rsp_q     <= '0;
            rsp_aux_q <= 1'b0;
            kf_v_q    <= 1'b0;
            kf_q      <= '0;
            af_v_q    <= 1'b0;
            af_q      <= '0;
            rst_q     <= 1'b0;
            xl_q      <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            stat_q    <= stat_d;
            outp_q    <= outp_d;
            rsp_v_q   <= rsp_v_d;
            rsp_q     <= rsp_d;
            rsp_aux_q <= rsp_aux_d;
            kf_v_q    <= kf_v_d;
            kf_q      <= kf_d;
            af_v_q    <= af_v_d;
            af_q      <= af_d;
            rst_q     <= rst_d;
            xl_q      <= xl_d;
            err_q     <= err_d;
        end
    end

    assign status_o        = stat_q;
    assign rsp_valid_o     = rsp_v_q;
    assign rsp_data_o      = rsp_q;
    assign rsp_aux_o       = rsp_aux_q;
    assign kbd_fwd_valid_o = kf_v_q;
    assign kbd_fwd_data_o  = kf_q;
    assign aux_fwd_valid_o = af_v_q;
    assign aux_fwd_data_o  = af_q;
    assign a20_o           = outp_q[OUTP_GATE_BIT];
    assign sys_rst_req_o   = rst_q;
    assign xlate_en_o      = xl_q;
    assign err_o           = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R10

    AST_SELFTEST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[STAT_TEST_BIT] |=> status_o[STAT_TEST_BIT]); // R5

    AST_PULSE_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'hF && !cmd_byte[0]) |=> sys_rst_req_o); // R7

    AST_PULSE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'hF && cmd_byte[0]) |=> !sys_rst_req_o); // R7

    AST_GATE_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hDF) |=> a20_o); // R8

    AST_GATE_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hDD) |=> !a20_o); // R8

    AST_ONE_OUTPUT_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_valid_o, kbd_fwd_valid_o, aux_fwd_valid_o})); // R13

endmodule

// File: tb/kbc_host_regs_tb_top.sv
`timescale 1ns/1ps
module kbc_host_regs_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_byte = '0;
    logic [7:0] status_o;
    logic       rsp_valid_o, rsp_aux_o;
    logic [7:0] rsp_data_o;
    logic       kbd_fwd_valid_o, aux_fwd_valid_o;
    logic [7:0] kbd_fwd_data_o, aux_fwd_data_o;
    logic       a20_o, sys_rst_req_o, xlate_en_o, err_o;

    always #2 clk = ~clk;

    kbc_host_regs dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .cmd_we          (cmd_we),
        .cmd_byte        (cmd_byte),
        .dat_we          (dat_we),
        .dat_byte        (dat_byte),
        .status_o        (status_o),
        .rsp_valid_o     (rsp_valid_o),
        .rsp_data_o      (rsp_data_o),
        .rsp_aux_o       (rsp_aux_o),
        .kbd_fwd_valid_o (kbd_fwd_valid_o),
        .kbd_fwd_data_o  (kbd_fwd_data_o),
        .aux_fwd_valid_o (aux_fwd_valid_o),
        .aux_fwd_data_o  (aux_fwd_data_o),
        .a20_o           (a20_o),
        .sys_rst_req_o   (sys_rst_req_o),
        .xlate_en_o      (xlate_en_o),
        .err_o           (err_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit mon_on = 1'b0;

    // scoreboard queues: {aux, data} for replies, data for forwards
    logic [8:0] rsp_q[$];
    string      rsp_tag_q[$];
    logic [7:0] kf_q[$];
    logic [7:0] af_q[$];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic exp_rsp(input string tag, input logic aux, input logic [7:0] d);
        rsp_q.push_back({aux, d});
        rsp_tag_q.push_back(tag);
    endtask

    task automatic send_cmd(input logic [7:0] c);
        cmd_we = 1'b1; cmd_byte = c;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic send_dat(input logic [7:0] d);
        dat_we = 1'b1; dat_byte = d;
        @(negedge clk);
        dat_we = 1'b0;
    endtask

    task automatic send_both(input logic [7:0] c, input logic [7:0] d);
        cmd_we = 1'b1; cmd_byte = c;
        dat_we = 1'b1; dat_byte = d;
        @(negedge clk);
        cmd_we = 1'b0; dat_we = 1'b0;
    endtask

    // monitor: pop expected items as outputs appear
    always @(negedge clk) begin
        if (mon_on) begin
            if (rsp_valid_o) begin
                if (rsp_q.size() == 0) begin
                    n_chk++; n_err++;
                    $display("FAIL R2 unexpected reply: actual=%01h_%02h expected=none",
                             rsp_aux_o, rsp_data_o);
                end else begin
                    logic [8:0] e;
                    string t;
                    e = rsp_q.pop_front();
                    t = rsp_tag_q.pop_front();
                    n_chk++;
                    if ({rsp_aux_o, rsp_data_o} !== e) begin
                        n_err++;
                        $display("FAIL %s reply: actual=%01h_%02h expected=%01h_%02h",
                                 t, rsp_aux_o, rsp_data_o, e[8], e[7:0]);
                    end
                end
            end
            if (kbd_fwd_valid_o) begin
                n_chk++;
                if (kf_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R4 unexpected keyboard forward: actual=%02h expected=none",
                             kbd_fwd_data_o);
                end else begin
                    logic [7:0] e;
                    e = kf_q.pop_front();
                    if (kbd_fwd_data_o !== e) begin
                        n_err++;
                        $display("FAIL R4 keyboard forward: actual=%02h expected=%02h",
                                 kbd_fwd_data_o, e);
                    end
                end
            end
            if (aux_fwd_valid_o) begin
                n_chk++;
                if (af_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R3 unexpected aux forward: actual=%02h expected=none",
                             aux_fwd_data_o);
                end else begin
                    logic [7:0] e;
                    e = af_q.pop_front();
                    if (aux_fwd_data_o !== e) begin
                        n_err++;
                        $display("FAIL R3 aux forward: actual=%02h expected=%02h",
                                 aux_fwd_data_o, e);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R1 reset state
        chk("R1 status", status_o, 8'h18);
        chk("R1 a20", {7'd0, a20_o}, 8'h01);
        chk("R1 rstreq", {7'd0, sys_rst_req_o}, 8'h00);
        chk("R1 xlate", {7'd0, xlate_en_o}, 8'h00);
        chk("R1 err", {7'd0, err_o}, 8'h00);
        chk("R1 valids", {5'd0, rsp_valid_o, kbd_fwd_valid_o, aux_fwd_valid_o}, 8'h00);

        // R2 read commands (reset values, R1)
        exp_rsp("R1 R2 mode", 1'b0, 8'h03); send_cmd(8'h20);
        exp_rsp("R1 R2 outport", 1'b0, 8'hCF); send_cmd(8'hD0);
        exp_rsp("R2 inport", 1'b0, 8'h80); send_cmd(8'hC0);

        // R5 tests
        exp_rsp("R5 selftest", 1'b0, 8'h55); send_cmd(8'hAA);
        chk("R5 status bit2", status_o, 8'h1C);
        exp_rsp("R5 kbd test", 1'b0, 8'h00); send_cmd(8'hAB);
        exp_rsp("R5 aux test", 1'b0, 8'h00); send_cmd(8'hA9);

        // R6 interface enables
        send_cmd(8'hA7); exp_rsp("R6 aux off", 1'b0, 8'h23); send_cmd(8'h20);
        send_cmd(8'hAD); exp_rsp("R6 kbd off", 1'b0, 8'h33); send_cmd(8'h20);
        send_cmd(8'hA8); exp_rsp("R6 aux on", 1'b0, 8'h13); send_cmd(8'h20);
        send_cmd(8'hAE); exp_rsp("R6 kbd on", 1'b0, 8'h03); send_cmd(8'h20);

        // R3 / R11 mode write
        send_cmd(8'h60); send_dat(8'h47);
        chk("R11 xlate set", {7'd0, xlate_en_o}, 8'h01);
        exp_rsp("R3 mode loaded", 1'b0, 8'h47); send_cmd(8'h20);
        chk("R11 xlate held", {7'd0, xlate_en_o}, 8'h01);
        send_cmd(8'h60); send_dat(8'h03);
        chk("R11 xlate clear", {7'd0, xlate_en_o}, 8'h00);

        // R3 reply injection and aux forwarding
        send_cmd(8'hD2); exp_rsp("R3 kbd reply", 1'b0, 8'h9A); send_dat(8'h9A);
        send_cmd(8'hD3); exp_rsp("R3 aux reply", 1'b1, 8'h5B); send_dat(8'h5B);
        send_cmd(8'hD4); af_q.push_back(8'hE6); send_dat(8'hE6);
        // R4 latch cleared: plain data goes to keyboard
        kf_q.push_back(8'hED); send_dat(8'hED);
        kf_q.push_back(8'h11); send_dat(8'h11);

        // R8 address gate commands
        send_cmd(8'hDD);
        chk("R8 a20 low", {7'd0, a20_o}, 8'h00);
        exp_rsp("R8 outport low", 1'b0, 8'hCD); send_cmd(8'hD0);
        send_cmd(8'hDF);
        chk("R8 a20 high", {7'd0, a20_o}, 8'h01);
        exp_rsp("R8 outport high", 1'b0, 8'hCF); send_cmd(8'hD0);

        // R9 output port writes
        send_cmd(8'hD1); send_dat(8'hCD);
        chk("R9 a20 from bit1", {7'd0, a20_o}, 8'h00);
        chk("R9 no reset", {7'd0, sys_rst_req_o}, 8'h00);
        exp_rsp("R9 outport", 1'b0, 8'hCD); send_cmd(8'hD0);
        send_cmd(8'hD1); send_dat(8'hCE);
        chk("R9 reset pulse", {7'd0, sys_rst_req_o}, 8'h01);
        chk("R9 a20 set", {7'd0, a20_o}, 8'h01);
        @(negedge clk);
        chk("R9 pulse ends", {7'd0, sys_rst_req_o}, 8'h00);
        send_cmd(8'hD1); send_dat(8'hCF);

        // R7 pulse commands
        send_cmd(8'hFE);
        chk("R7 FE pulse", {7'd0, sys_rst_req_o}, 8'h01);
        @(negedge clk);
        chk("R7 FE one cycle", {7'd0, sys_rst_req_o}, 8'h00);
        send_cmd(8'hF0);
        chk("R7 F0 pulse", {7'd0, sys_rst_req_o}, 8'h01);
        send_cmd(8'hFF);
        chk("R7 FF none", {7'd0, sys_rst_req_o}, 8'h00);
        send_cmd(8'hF1);
        chk("R7 F1 none", {7'd0, sys_rst_req_o}, 8'h00);
        chk("R7 no err", {7'd0, err_o}, 8'h00);

        // R12 latch survives single-phase command, replaced by two-phase
        send_cmd(8'hD2);
        exp_rsp("R12 interleaved test", 1'b0, 8'h00); send_cmd(8'hAB);
        exp_rsp("R12 latch kept", 1'b0, 8'h77); send_dat(8'h77);
        send_cmd(8'hD2); send_cmd(8'hD3);
        exp_rsp("R12 latch replaced", 1'b1, 8'h66); send_dat(8'h66);

        // R13 simultaneous command and data
        send_cmd(8'hD2);
        exp_rsp("R13 command wins", 1'b0, 8'h03); send_both(8'h20, 8'h44);
        exp_rsp("R13 latch untouched", 1'b0, 8'h45); send_dat(8'h45);
        exp_rsp("R13 idle both", 1'b0, 8'h00); send_both(8'hA9, 8'h12);

        // R10 unknown command
        send_cmd(8'hA1);
        chk("R10 err set", {7'd0, err_o}, 8'h01);
        chk("R10 status kept", status_o, 8'h1C);
        exp_rsp("R10 mode kept", 1'b0, 8'h03); send_cmd(8'h20);
        exp_rsp("R10 outport kept", 1'b0, 8'hCF); send_cmd(8'hD0);
        @(negedge clk);
        chk("R10 err sticky", {7'd0, err_o}, 8'h01);

        repeat (2) @(negedge clk);
        mon_on = 1'b0;
        n_chk++;
        if (rsp_q.size() != 0 || kf_q.size() != 0 || af_q.size() != 0) begin
            n_err++;
            $display("FAIL R2 missing outputs: actual=%0d expected=0",
                     rsp_q.size() + kf_q.size() + af_q.size());
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule